// File: doc/BRIEF.md
# SDRAM Open-Row Tracker and Energy Estimator

This block observes a stream of word-addressed memory requests aimed at a banked SDRAM. For each bank it remembers which row is open. It sorts every accepted request as either a page hit or a page break. A page break is an access to a closed bank, or to a row other than the one that bank holds open.

From that classification it keeps several running totals:

- hits and breaks (activations);
- data words moved;
- estimated bus cycles, including the cycles lost to precharge and activate;
- an energy estimate in fixed-point tenths of a nanojoule, with data and activation energy kept apart and also offered as a combined sum.

The block is a passive estimator placed beside a memory path. It drives no device. It accepts a request whenever it is not being cleared. Its counters can be read at any time.

Top module: `sdram_row_tracker`

## Requirements
- R1: The bank is word address bits [COL_W+BANK_W-1:COL_W], which is [9:8] by default. The row is every bit above the bank field. The low COL_W column bits (8 by default) never affect the hit/break decision.
- R2: After reset every bank is closed, so the first access to each bank is a page break. All counters read zero and `req_ready` is 1.
- R3: An accepted request to a bank whose open row equals the request row is a page hit. It increments `hit_cnt` and leaves `break_cnt` and `e_act` unchanged.
- R4: An accepted request to a closed bank or to a different row is a page break. It increments `break_cnt`, adds E_ACT+E_ACT_STAT (130+70 = 200) to `e_act`, and leaves that row open in that bank.
- R5: `req_burst`=1 moves BURST_LEN (4) words and `req_burst`=0 moves one word. `word_cnt` grows by that number, and `e_data` grows by E_WORD (36) per word.
- R6: `cycle_cnt` grows by T_CL+words on a hit and by T_RP+T_RCD+T_CL+words on a break. With the defaults of 2 each, that is 2+words on a hit and 6+words on a break.
- R7: `e_total` always equals `e_data`+`e_act`, saturated at the all-ones value.
- R8: Every counter saturates at all-ones and holds that value until it is cleared.
- R9: While `clr` is 1, `req_ready` is 0 and no request is accepted. The cycle after `clr`, every counter is zero and every bank is closed.
- R10: Opening a row in one bank does not disturb the open row of any other bank.
- R11: Counters change on the clock edge that accepts a request, and they hold when no request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of counters and bank state |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high with `req_valid` |
| req_addr | input | ADDR_W | Word address |
| req_burst | input | 1 | 1: burst of BURST_LEN words, 0: single word |
| hit_cnt | output | CNT_W | Page hits |
| break_cnt | output | CNT_W | Page breaks (activations) |
| word_cnt | output | CNT_W | Words transferred |
| cycle_cnt | output | CNT_W | Estimated bus cycles |
| e_data | output | CNT_W | Data energy, 0.1 nJ units |
| e_act | output | CNT_W | Activation energy, 0.1 nJ units |
| e_total | output | CNT_W | Saturated sum of data and activation energy |

## Verification
The bench builds the block with ADDR_W=16 and CNT_W=12. The default bank mapping and energy weights are kept, so the row is address bits [15:10]. The 12-bit counters let thirty bursts to one row drive `e_data` and `e_total` into saturation within a short run, while `word_cnt` and `cycle_cnt` stay below the limit. The short row field lets a few addresses reach all four banks and several rows per bank.

// File: rtl/sdram_row_tracker.sv
module sdram_row_tracker #(
  parameter int ADDR_W     = 24,
  parameter int COL_W      = 8,
  parameter int BANK_W     = 2,
  parameter int CNT_W      = 32,
  parameter int BURST_LEN  = 4,
  parameter int E_WORD     = 36,
  parameter int E_ACT      = 130,
  parameter int E_ACT_STAT = 70,
  parameter int T_RP       = 2,
  parameter int T_RCD      = 2,
  parameter int T_CL       = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_burst,
  output logic [CNT_W-1:0]  hit_cnt,
  output logic [CNT_W-1:0]  break_cnt,
  output logic [CNT_W-1:0]  word_cnt,
  output logic [CNT_W-1:0]  cycle_cnt,
  output logic [CNT_W-1:0]  e_data,
  output logic [CNT_W-1:0]  e_act,
  output logic [CNT_W-1:0]  e_total
);
  localparam int NBANK = 1 << BANK_W;
  localparam int ROW_W = ADDR_W - COL_W - BANK_W;
  localparam logic [CNT_W-1:0] MAXV = '1;

  logic [NBANK-1:0] open_q;
  logic [ROW_W-1:0] row_q [NBANK];

  function automatic logic [CNT_W-1:0] sat_add(input logic [CNT_W-1:0] a, input logic [CNT_W-1:0] b);
    logic [CNT_W:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[CNT_W] ? MAXV : s[CNT_W-1:0];
  endfunction

  wire [BANK_W-1:0] bank = req_addr[COL_W +: BANK_W];
  wire [ROW_W-1:0]  row  = req_addr[ADDR_W-1 -: ROW_W];
  wire unused_col = ^req_addr[COL_W-1:0];

  assign req_ready = ~clr;
  wire accept = req_valid & req_ready;
  wire is_hit = open_q[bank] && (row_q[bank] == row);

  wire [CNT_W-1:0] words   = req_burst ? CNT_W'(BURST_LEN) : CNT_W'(1);
  wire [CNT_W-1:0] dat_inc = req_burst ? CNT_W'(BURST_LEN * E_WORD) : CNT_W'(E_WORD);
  wire [CNT_W-1:0] cyc_inc = words + (is_hit ? CNT_W'(T_CL) : CNT_W'(T_RP + T_RCD + T_CL));
  wire [CNT_W-1:0] act_inc = CNT_W'(E_ACT + E_ACT_STAT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q    <= '0;
      hit_cnt   <= '0;
      break_cnt <= '0;
      word_cnt  <= '0;
      cycle_cnt <= '0;
      e_data    <= '0;
      e_act     <= '0;
    end else if (clr) begin
      open_q    <= '0;
      hit_cnt   <= '0;
      break_cnt <= '0;
      word_cnt  <= '0;
      cycle_cnt <= '0;
      e_data    <= '0;
      e_act     <= '0;
    end else if (accept) begin
      open_q[bank] <= 1'b1;
      word_cnt     <= sat_add(word_cnt, words);
      cycle_cnt    <= sat_add(cycle_cnt, cyc_inc);
      e_data       <= sat_add(e_data, dat_inc);
      if (is_hit) begin
        hit_cnt <= sat_add(hit_cnt, CNT_W'(1));
      end else begin
        break_cnt <= sat_add(break_cnt, CNT_W'(1));
        e_act     <= sat_add(e_act, act_inc);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (accept) row_q[bank] <= row;
  end

  assign e_total = sat_add(e_data, e_act);

  assert_hit_keeps_act_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && is_hit) |=> ($stable(break_cnt) && $stable(e_act)));

  assert_break_counts_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !is_hit && break_cnt != MAXV) |=> (break_cnt == $past(break_cnt) + 1'b1));

  assert_total_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (e_total >= e_data) && (e_total >= e_act));

  assert_word_sat_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (word_cnt == MAXV && !clr) |=> (word_cnt == MAXV));

  assert_clear_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (hit_cnt == '0 && break_cnt == '0 && word_cnt == '0 && e_data == '0 && e_act == '0));

  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!accept && !clr) |=> ($stable(word_cnt) && $stable(cycle_cnt) && $stable(hit_cnt)));
endmodule

// File: tb/sdram_row_tracker_test.sv
module sdram_row_tracker_test;
  localparam int AW = 16;
  localparam int CW = 12;

  logic clk = 0, rst_n = 0, clr = 0, req_valid = 0, req_burst = 0;
  logic [AW-1:0] req_addr = '0;
  logic req_ready;
  logic [CW-1:0] hit_cnt, break_cnt, word_cnt, cycle_cnt, e_data, e_act, e_total;

  always #5 clk = ~clk;

  sdram_row_tracker #(.ADDR_W(AW), .CNT_W(CW)) uut (
    .clk(clk), .rst_n(rst_n), .clr(clr), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_burst(req_burst), .hit_cnt(hit_cnt), .break_cnt(break_cnt),
    .word_cnt(word_cnt), .cycle_cnt(cycle_cnt), .e_data(e_data), .e_act(e_act), .e_total(e_total));

  int tests = 0, fails = 0;
  int m_hit, m_brk, m_word, m_cyc, m_edat, m_eact;

  // {burst, addr[15:0], expected break}
  localparam logic [17:0] VEC [12] = '{
    {1'b1, 16'h0000, 1'b1}, {1'b1, 16'h0004, 1'b0}, {1'b0, 16'h00FF, 1'b0},
    {1'b1, 16'h0100, 1'b1}, {1'b1, 16'h0010, 1'b0}, {1'b1, 16'h0400, 1'b1},
    {1'b0, 16'h0000, 1'b1}, {1'b1, 16'h0200, 1'b1}, {1'b1, 16'h0300, 1'b1},
    {1'b0, 16'h0120, 1'b0}, {1'b1, 16'h0A01, 1'b1}, {1'b1, 16'h0A80, 1'b0}};

  task automatic chk(input string req, input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int sat(input int v);
    return (v > 4095) ? 4095 : v;
  endfunction

  task automatic model(input logic brk, input logic burst);
    int w;
    w = burst ? 4 : 1;
    if (brk) begin m_brk++; m_eact += 200; m_cyc += 6 + w; end
    else begin m_hit++; m_cyc += 2 + w; end
    m_word += w;
    m_edat += 36 * w;
  endtask

  task automatic access(input logic [AW-1:0] a, input logic b);
    @(negedge clk);
    req_addr = a; req_burst = b; req_valid = 1;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic check_all(input string req);
    chk(req, "hit_cnt", int'(hit_cnt), sat(m_hit));
    chk(req, "break_cnt", int'(break_cnt), sat(m_brk));
    chk(req, "word_cnt", int'(word_cnt), sat(m_word));
    chk(req, "cycle_cnt", int'(cycle_cnt), sat(m_cyc));
    chk(req, "e_data", int'(e_data), sat(m_edat));
    chk(req, "e_act", int'(e_act), sat(m_eact));
    chk("R7", "e_total", int'(e_total), sat(sat(m_edat) + sat(m_eact)));
  endtask

  task automatic model_zero;
    m_hit = 0; m_brk = 0; m_word = 0; m_cyc = 0; m_edat = 0; m_eact = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    model_zero();
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R2", "req_ready", int'(req_ready), 1);
    check_all("R2");

    // R1 R3 R4 R5 R6 R10: table walk
    for (int i = 0; i < 12; i++) begin
      access(VEC[i][16:1], VEC[i][17]);
      model(VEC[i][0], VEC[i][17]);
      check_all(VEC[i][0] ? "R4" : "R3");
    end

    // R11: idle cycles change nothing
    repeat (3) @(negedge clk);
    check_all("R11");

    // R9: clear with a request pending, not accepted
    @(negedge clk);
    clr = 1; req_valid = 1; req_addr = 16'h0A80; req_burst = 1;
    #1 chk("R9", "req_ready during clr", int'(req_ready), 0);
    @(negedge clk);
    clr = 0; req_valid = 0;
    model_zero();
    check_all("R9");

    // R9 R2: banks closed after clear, so the old open row breaks
    access(16'h0A80, 1'b1);
    model(1'b1, 1'b1);
    check_all("R9");
    access(16'h0A84, 1'b0);
    model(1'b0, 1'b0);
    check_all("R1");

    // R8: saturation of energy counters
    @(negedge clk); clr = 1; @(negedge clk); clr = 0;
    model_zero();
    for (int k = 0; k < 30; k++) begin
      access(16'h0C00, 1'b1);
      model(k == 0, 1'b1);
    end
    check_all("R8");
    chk("R8", "e_data saturated", int'(e_data), 4095);
    chk("R8", "e_total saturated", int'(e_total), 4095);
    access(16'h0C00, 1'b1);
    model(1'b0, 1'b1);
    chk("R8", "e_data held", int'(e_data), 4095);
    chk("R8", "word_cnt", int'(word_cnt), 124);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule